// File: doc/BRIEF.md
# Multiplexed-Bus Memory Copy Sequencer

This block is a bus master that copies a run of bytes from one place in a 14-bit video memory space to another. It talks to memory over a multiplexed interface. The low eight address bits share a bidirectional address/data bus with the data. The upper six address bits have dedicated lines. An address-latch strobe marks the address phase, and separate active-low read and write strobes mark the data phases. The shared bus is modelled as an output value, an output enable and an input value, so the chip's pad ring can build the tri-state driver.

The host loads a source base, a destination base and a byte count, then pulses `start`. For each byte the engine runs four one-cycle bus phases in a fixed order:

1. Latch the source address.
2. Read, capturing the returned byte into a holding register.
3. Latch the destination address.
4. Write the held byte.

Both addresses step by one per byte and wrap modulo 2^14. A typical job copies pattern bytes from 0x0000 upward into the name-table area at 0x2000 or the palette area at 0x3F00.

Top module: `vram_copy_engine`

## Requirements
- R1: After reset the engine is idle: `busy`=0, `done`=0, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0.
- R2: In an address phase `ale`=1, `rd_n`=`wr_n`=1, `ad_oe`=1, and `{a_hi, ad_o}` carries the full 14-bit address: bits 13:8 on `a_hi` and bits 7:0 on `ad_o`.
- R3: A read data phase lasts exactly one cycle, with `ale`=0, `ad_oe`=0 and `rd_n`=0. The value on `ad_i` at the clock edge that ends this phase is held. `ad_i` is ignored in every other cycle.
- R4: A write data phase lasts one cycle, with `ale`=0, `rd_n`=1, `wr_n`=0 and `ad_oe`=1, and `ad_o` equal to the byte held from the preceding read.
- R5: Each byte takes the phases source-address, read, destination-address, write, in that order. Byte i moves from (source base + i) mod 2^14 to (destination base + i) mod 2^14.
- R6: `ad_oe` is never 1 while `rd_n`=0. `rd_n` and `wr_n` are never both 0. Neither strobe is 0 while `ale`=1.
- R7: In the cycle after the final write phase, `done` is 1 for exactly one cycle, with `busy`=0, all strobes inactive and `ad_oe`=0.
- R8: A `start` pulse while `busy`=1 is ignored; the running copy finishes with its original parameters.
- R9: A start with a count of zero raises `done` in the next cycle, keeps `busy` at 0 and produces no bus phase.
- R10: A copy of N bytes holds `busy` high for exactly 4N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus phase per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a copy; sampled only while idle |
| src_base | input | 14 | First source address |
| dst_base | input | 14 | First destination address |
| count | input | 15 | Number of bytes to move |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle completion pulse |
| ad_i | input | 8 | Value seen on the shared address/data bus |
| ad_o | output | 8 | Value driven onto the shared bus |
| ad_oe | output | 1 | Drive enable for the shared bus |
| a_hi | output | 6 | Upper address bits 13:8 |
| ale | output | 1 | Address-latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The properties assume that `rst_n` is held low for at least one clock edge before any stimulus, and that `start` and the base/count inputs change only between clock edges. They also assume the memory returns read data on `ad_i` within the read cycle. The bench drives every input on the falling edge. It answers reads from a memory model keyed by the address it latched on `ale`. Whenever `rd_n` is high it puts fresh random values on `ad_i`, so a capture in the wrong cycle shows up as corrupted data. Random jobs use seeded source bases, destination bases and lengths of 1 to 24 bytes. They sit beside directed cases for zero length, single bytes, address wrap, overlapping forward copies and a second start issued mid-copy.

// File: rtl/vram_copy_engine.sv
module vram_copy_engine #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [ADDR_W-1:0]          src_base,
  input  logic [ADDR_W-1:0]          dst_base,
  input  logic [CNT_W-1:0]           count,
  output logic                       busy,
  output logic                       done,
  input  logic [DATA_W-1:0]          ad_i,
  output logic [DATA_W-1:0]          ad_o,
  output logic                       ad_oe,
  output logic [ADDR_W-DATA_W-1:0]   a_hi,
  output logic                       ale,
  output logic                       rd_n,
  output logic                       wr_n
);
  localparam int HI_W = ADDR_W - DATA_W;

  typedef enum logic [2:0] {S_IDLE, S_RADDR, S_RDATA, S_WADDR, S_WDATA} phase_t;

  phase_t            phase;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] hold_q;
  logic              done_q;

  wire               on_src   = (phase == S_RADDR) || (phase == S_RDATA);
  wire [ADDR_W-1:0]  cur_addr = on_src ? src_q : dst_q;
  wire               last     = (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      left_q <= '0;
      hold_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        S_IDLE:
          if (start) begin
            if (count == '0) begin
              done_q <= 1'b1;
            end else begin
              src_q  <= src_base;
              dst_q  <= dst_base;
              left_q <= count;
              phase  <= S_RADDR;
            end
          end
        S_RADDR: phase <= S_RDATA;
        S_RDATA: begin
          hold_q <= ad_i;
          phase  <= S_WADDR;
        end
        S_WADDR: phase <= S_WDATA;
        S_WDATA: begin
          left_q <= left_q - CNT_W'(1);
          src_q  <= src_q + ADDR_W'(1);
          dst_q  <= dst_q + ADDR_W'(1);
          if (last) begin
            done_q <= 1'b1;
            phase  <= S_IDLE;
          end else begin
            phase  <= S_RADDR;
          end
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  assign busy  = (phase != S_IDLE);
  assign done  = done_q;
  assign ale   = (phase == S_RADDR) || (phase == S_WADDR);
  assign rd_n  = (phase != S_RDATA);
  assign wr_n  = (phase != S_WDATA);
  assign ad_oe = ale || (phase == S_WDATA);
  assign ad_o  = (phase == S_WDATA) ? hold_q :
                 (ale ? cur_addr[DATA_W-1:0] : '0);
  assign a_hi  = busy ? cur_addr[ADDR_W-1:DATA_W] : HI_W'(0);
endmodule

// File: rtl/vram_copy_engine_chk.sv
module vram_copy_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe
);
  // R6
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> wr_n);
  // R6
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));
  // R2
  addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && busy));
  // R3
  read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |=> (rd_n && ale));
  // R5
  write_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> (ale || done));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !ad_oe && rd_n && wr_n && !ale));
endmodule

bind vram_copy_engine vram_copy_engine_chk u_chk (.*);

// File: tb/vram_copy_engine_test.sv
module vram_copy_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AMASK = 16'h3FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [13:0] src_base = '0, dst_base = '0;
  logic [14:0] count = '0;
  logic        busy, done, ad_oe, ale, rd_n, wr_n;
  logic [7:0]  ad_i = '0, ad_o;
  logic [5:0]  a_hi;

  vram_copy_engine uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  logic [7:0] mem [int];
  logic [7:0] expm [int];
  int addr_q [$];
  int latch_addr = 0;
  int busy_cnt, done_cnt, rd_cnt, wr_cnt, viol_cnt;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7) ^ (a >> 5) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] mread(int a);
    return mem.exists(a) ? mem[a] : pat(a);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory side: latch address, take writes
  always @(posedge clk) begin
    if (!wr_n) mem[latch_addr] = ad_o;
    if (ale) latch_addr = {a_hi, ad_o};
  end

  // bus observer and read responder
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (done) done_cnt++;
      if (ale) begin
        addr_q.push_back({a_hi, ad_o});
        if (!ad_oe || !rd_n || !wr_n) viol_cnt++;
      end
      if (!rd_n) begin
        rd_cnt++;
        if (ad_oe || !wr_n) viol_cnt++;
      end
      if (!wr_n) begin
        wr_cnt++;
        if (!ad_oe) viol_cnt++;
      end
    end
    ad_i <= !rd_n ? mread(latch_addr) : 8'($urandom);
  end

  task automatic run_copy(int s, int d, int n, bit poke);
    int waited;
    expm = mem;
    for (int i = 0; i < n; i++) begin
      int sa = (s + i) & AMASK;
      int da = (d + i) & AMASK;
      expm[da] = expm.exists(sa) ? expm[sa] : pat(sa);
    end
    busy_cnt = 0; done_cnt = 0; rd_cnt = 0; wr_cnt = 0; viol_cnt = 0;
    addr_q.delete();
    @(negedge clk);
    start = 1'b1; src_base = 14'(s); dst_base = 14'(d); count = 15'(n);
    @(negedge clk);
    start = 1'b0; src_base = 14'($urandom); dst_base = 14'($urandom); count = 15'($urandom);
    waited = 1;
    while (!done && waited < 4 * n + 20) begin
      if (poke && waited == 3) start = 1'b1;       // R8 stray start
      else start = 1'b0;
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    // R7 state on the done cycle
    chk(done === 1'b1, "R7", done, 1);
    chk(!busy && !ale && rd_n && wr_n && !ad_oe, "R7",
        {busy, ale, rd_n, wr_n, ad_oe}, 5'b00110);
    repeat (2) @(negedge clk);
    chk(done_cnt == 1, "R7", done_cnt, 1);
    chk(busy_cnt == 4 * n, n == 0 ? "R9" : "R10", busy_cnt, 4 * n);
    chk(rd_cnt == n && wr_cnt == n, "R3", rd_cnt + wr_cnt, 2 * n);
    chk(viol_cnt == 0, "R6", viol_cnt, 0);
    chk(addr_q.size() == 2 * n, "R2", addr_q.size(), 2 * n);
    for (int i = 0; i < n && 2 * i + 1 < addr_q.size(); i++) begin
      chk(addr_q[2*i] == ((s + i) & AMASK), "R5", addr_q[2*i], (s + i) & AMASK);
      chk(addr_q[2*i+1] == ((d + i) & AMASK), "R5", addr_q[2*i+1], (d + i) & AMASK);
    end
    for (int i = 0; i < n; i++) begin
      int da = (d + i) & AMASK;
      chk(mread(da) == expm[da], poke ? "R8" : "R4", mread(da), expm[da]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !ale && rd_n && wr_n && !ad_oe, "R1",
        {busy, done, ale, rd_n, wr_n, ad_oe}, 6'b000110);
    rst_n = 1'b1;
    @(negedge clk);
    run_copy(16'h0000, 16'h2000, 16, 0);   // R5 pattern to name table
    run_copy(16'h000A, 16'h3F0A, 16, 0);   // R5 pattern to palette
    run_copy(16'h1234, 16'h2345, 0, 0);    // R9 empty job
    run_copy(16'h0100, 16'h0300, 1, 0);    // single byte
    run_copy(16'h3FFE, 16'h1000, 4, 0);    // R5 source wrap
    run_copy(16'h0200, 16'h3FFD, 5, 0);    // R5 destination wrap
    run_copy(16'h0400, 16'h0401, 8, 0);    // overlapping forward copy
    run_copy(16'h0800, 16'h2800, 10, 1);   // R8 start while busy
    for (int k = 0; k < 8; k++)
      run_copy(int'($urandom) & AMASK, int'($urandom) & AMASK,
               1 + int'($urandom % 24), k == 5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule